// File: doc/BRIEF.md
# Single-Wire Response Receiver

This block recovers the reply that a game-pad controller sends back over a shared bidirectional line after it has been sent a command. The controller runs from its own oscillator, so there is no common clock. The receiver brings the raw line into its own clock domain through a two-stage synchronizer. It treats every high-to-low transition as the start of a new bit. It then reads the line level a fixed number of cycles later and treats that level as the bit's value.

A host arms the block with a one-cycle strobe and the number of bits it expects, for example 32 for a button-state reply. The received bits collect most significant first into a word that is right-justified to the requested length. When the last expected bit has been taken, the word moves to the output register and valid rises. The stop bit that follows the reply falls on an idle receiver and has no effect. If the controller goes silent part way through a reply, or never answers, a per-bit watchdog produces a single-cycle timeout pulse and returns the block to idle. The host can then poll again or reset the controller.

Top module: `rx_resp_receiver`

## Requirements
- R1: After reset, data_o is all zeros, and valid_o and timeout_o are 0.
- R2: Each high-to-low transition of the synchronized line starts a bit while a reply is expected. The bit's value is the synchronized line level SAMPLE_DLY clock cycles after that transition is detected (default 54).
- R3: valid_o rises only once the number of bits given on nbits_i at arming has been captured. It then stays high until the next accepted arm strobe.
- R4: Bits fill the word most significant first, and the first bit received lands at position nbits-1. Bits above nbits-1 are zero. data_o changes only when a reply completes, and it holds its value through later line activity while the block is idle, including the trailing stop bit.
- R5: While a bit is awaited, TIMEOUT_CYC cycles without a falling edge (default 2700) cause timeout_o to pulse for exactly one cycle. The block then goes idle, valid_o stays 0, and data_o keeps its previous value.
- R6: An accepted arm strobe given while a reply is in progress discards the partial reply and starts a fresh one with the new bit count.
- R7: An arm strobe with nbits_i equal to 0 or greater than MAX_BITS is ignored: the state, valid_o and the watchdog are unchanged.
- R8: A full-width reply of MAX_BITS bits (default 32) is captured with no lost or extra bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Raw level of the shared controller line, asynchronous |
| arm_i | input | 1 | One-cycle strobe that starts waiting for a reply |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of reply bits expected, sampled with arm_i |
| data_o | output | MAX_BITS | Last completed reply, right-justified |
| valid_o | output | 1 | High once a reply has completed, until the next arm |
| timeout_o | output | 1 | One-cycle pulse when an expected bit never starts |

## Verification
The assertions assume that arm_i is a single-cycle strobe and that line_i stays high whenever no bit is in flight. From this they take that the only way valid_o can rise is a completed capture, and that a timeout can only occur with valid_o low. The stimulus drives every bit as a low start section, then a data section long enough to cover the sample point, then a high section. This keeps each data level stable across the instant at which the block reads it. The gap between bits stays well inside the watchdog window, except in the tests that stop the line on purpose to force a timeout.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE        = 2'd0,
    RX_WAIT_EDGE   = 2'd1,
    RX_WAIT_SAMPLE = 2'd2
  } rx_state_e;

  // A requested frame length is usable when it is non-zero and fits the word.
  function automatic logic frame_len_ok(input int unsigned n, input int unsigned max_bits);
    return (n != 0) && (n <= max_bits);
  endfunction

  // Counter width needed to count 0 .. limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic fall_evt
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s   = sync_q;
  assign fall_evt = prev_q & ~sync_q;

  // A detected edge lasts one cycle only.
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/rx_delay_cnt.sv
module rx_delay_cnt #(
  parameter int unsigned LIMIT = 54
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = rx_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (en)       cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int unsigned MAX_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                shift_en,
  input  logic                bit_i,
  output logic [MAX_BITS-1:0] word_next
);
  logic [MAX_BITS-1:0] word_q;

  assign word_next = {word_q[MAX_BITS-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  word_q <= '0;
    else if (shift_en)  word_q <= word_next;
  end

endmodule

// File: rtl/rx_resp_receiver.sv
module rx_resp_receiver #(
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned SAMPLE_DLY  = 54,
  parameter int unsigned TIMEOUT_CYC = 2700,
  localparam int unsigned NW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_i,
  input  logic                arm_i,
  input  logic [NW-1:0]       nbits_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                timeout_o
);
  import rx_pkg::*;

  rx_state_e           state_q;
  logic [NW-1:0]       remain_q;
  logic                line_s, fall_evt;
  logic                arm_ok, sample_evt, wd_hit, timeout_evt, last_bit;
  logic [MAX_BITS-1:0] word_next;

  assign arm_ok = arm_i && frame_len_ok(int'(nbits_i), MAX_BITS);

  rx_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .line_s(line_s), .fall_evt(fall_evt)
  );

  rx_delay_cnt #(.LIMIT(SAMPLE_DLY)) u_sample (
    .clk(clk), .rst_n(rst_n),
    .clr(arm_ok || state_q != RX_WAIT_SAMPLE),
    .en(state_q == RX_WAIT_SAMPLE && !arm_ok),
    .hit(sample_evt)
  );

  rx_delay_cnt #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n),
    .clr(arm_ok || state_q != RX_WAIT_EDGE || fall_evt),
    .en(state_q == RX_WAIT_EDGE && !arm_ok && !fall_evt),
    .hit(wd_hit)
  );

  assign timeout_evt = wd_hit;
  assign last_bit    = sample_evt && (remain_q == NW'(1));

  rx_shifter #(.MAX_BITS(MAX_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(arm_ok),
    .shift_en(sample_evt), .bit_i(line_s), .word_next(word_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      remain_q  <= '0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else if (arm_ok) begin
      state_q   <= RX_WAIT_EDGE;
      remain_q  <= nbits_i;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      unique case (state_q)
        RX_WAIT_EDGE: begin
          if (fall_evt) state_q <= RX_WAIT_SAMPLE;
          else if (timeout_evt) begin
            state_q   <= RX_IDLE;
            timeout_o <= 1'b1;
          end
        end
        RX_WAIT_SAMPLE: begin
          if (sample_evt) begin
            remain_q <= remain_q - 1'b1;
            if (last_bit) begin
              data_o  <= word_next;
              valid_o <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              state_q <= RX_WAIT_EDGE;
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  p_valid_from_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(sample_evt));

  p_data_on_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> $rose(valid_o));

  p_timeout_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  p_timeout_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!valid_o && state_q == RX_IDLE));

  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> (state_q == RX_WAIT_EDGE && !valid_o));

  p_arm_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !arm_ok && valid_o) |=> valid_o);

endmodule

// File: tb/rx_resp_receiver_test.sv
`timescale 1ns/1ps
module rx_resp_receiver_test;
  localparam int MAXB = 32;
  localparam int SDLY = 54;
  localparam int TOUT = 2700;
  localparam int NW   = $clog2(MAXB + 1);
  localparam int LO   = 27;
  localparam int DA   = 54;
  localparam int HI   = 27;
  localparam int NVEC = 7;

  localparam int          VEC_N [NVEC] = '{32, 32, 8, 1, 1, 16, 32};
  localparam logic [31:0] VEC_W [NVEC] = '{32'hA5C3_0F96, 32'h8000_0001,
                                           32'h0000_003C, 32'h1, 32'h0,
                                           32'h0000_FFFF, 32'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic arm = 1'b0;
  logic [NW-1:0] nbits = '0;
  logic [MAXB-1:0] data;
  logic valid, tout;

  int checks = 0;
  int failures = 0;
  int to_cnt = 0;
  int to_run = 0;
  int to_maxrun = 0;

  always #2 clk = ~clk;

  rx_resp_receiver #(.MAX_BITS(MAXB), .SAMPLE_DLY(SDLY), .TIMEOUT_CYC(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .arm_i(arm), .nbits_i(nbits),
    .data_o(data), .valid_o(valid), .timeout_o(tout)
  );

  always @(posedge clk) begin
    if (tout) begin
      to_cnt <= to_cnt + 1;
      to_run <= to_run + 1;
      if (to_run + 1 > to_maxrun) to_maxrun <= to_run + 1;
    end else to_run <= 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm(input int n);
    @(negedge clk);
    arm = 1'b1; nbits = NW'(n);
    @(negedge clk);
    arm = 1'b0;
    cycles(3);
  endtask

  task automatic drive_bit(input logic b);
    line = 1'b0; cycles(LO);
    line = b;    cycles(DA);
    line = 1'b1; cycles(HI);
  endtask

  task automatic send(input int n, input logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) drive_bit(w[i]);
  endtask

  task automatic send_stop();
    line = 1'b0; cycles(LO);
    line = 1'b1; cycles(DA + HI);
  endtask

  function automatic logic [31:0] right_just(input int n, input logic [31:0] w);
    return (n >= 32) ? w : (w & ((32'h1 << n) - 32'h1));
  endfunction

  initial begin
    int base;
    cycles(5);
    // R1 reset state
    check("R1 data", data, 32'h0);
    check("R1 valid", {31'h0, valid}, 32'h0);
    check("R1 timeout", {31'h0, tout}, 32'h0);
    rst_n = 1'b1;
    cycles(5);

    // R2 R3 R4 R8: table of frames, each followed by a stop bit
    for (int v = 0; v < NVEC; v++) begin
      do_arm(VEC_N[v]);
      send(VEC_N[v], VEC_W[v]);
      send_stop();
      cycles(10);
      check("R2 R4 R8 frame data", data, right_just(VEC_N[v], VEC_W[v]));
      check("R3 valid after frame", {31'h0, valid}, 32'h1);
    end

    // R4: unarmed line activity leaves data and valid alone
    send(8, 32'h0000_00FF);
    cycles(10);
    check("R4 idle data held", data, 32'h0);
    check("R4 idle valid held", {31'h0, valid}, 32'h1);

    // R3: valid stays low on a partial frame
    do_arm(8);
    send(4, 32'hF);
    check("R3 valid low mid frame", {31'h0, valid}, 32'h0);
    send(4, 32'h3);
    cycles(10);
    check("R3 data complete", data, 32'h0000_00F3);

    // R5: reply stops after three bits
    base = to_cnt;
    do_arm(8);
    send(3, 32'h5);
    cycles(TOUT + 50);
    check("R5 one timeout", to_cnt - base, 1);
    check("R5 pulse width", to_maxrun, 1);
    check("R5 valid low", {31'h0, valid}, 32'h0);
    check("R5 data kept", data, 32'h0000_00F3);
    send(8, 32'hAA);
    cycles(10);
    check("R5 idle after timeout", data, 32'h0000_00F3);
    check("R5 no valid after timeout", {31'h0, valid}, 32'h0);

    // R5: no reply at all
    base = to_cnt;
    do_arm(4);
    cycles(TOUT + 50);
    check("R5 silent timeout", to_cnt - base, 1);

    // R6: re-arm mid frame
    do_arm(8);
    send(3, 32'h7);
    do_arm(8);
    send(8, 32'h5A);
    cycles(10);
    check("R6 restart data", data, 32'h0000_005A);
    check("R6 restart valid", {31'h0, valid}, 32'h1);

    // R7: arms with zero or oversize counts are ignored
    base = to_cnt;
    do_arm(0);
    check("R7 zero arm valid", {31'h0, valid}, 32'h1);
    do_arm(MAXB + 1);
    check("R7 oversize arm valid", {31'h0, valid}, 32'h1);
    cycles(TOUT + 50);
    check("R7 no timeout", to_cnt - base, 0);
    send(8, 32'h11);
    cycles(10);
    check("R7 data held", data, 32'h0000_005A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule